// File: doc/BRIEF.md
# Table-Driven Multi-Move Sequencer

On a single trigger, this channel controller performs a short series of memory-to-memory moves. The number of moves is set by a 3-bit repeat field. Each move copies one unit, either a byte or a 16-bit halfword, from a source address to a destination address.

The addresses are not held in registers. They live in a table in memory, placed just after the channel's mode word and count word. The table alternates source and destination entries, one pair per move.

The sequencer uses one master port that makes one request at a time. For each move it reads the source entry, then the destination entry, then the data unit, and finally writes the unit. While a sequence is running it holds an interrupt-inhibit output high. When the last write is acknowledged it raises a one-cycle completion pulse. If the repeat field is zero, it reports an error and performs no moves.

Top module: `mxfer_seq`

## Requirements
- R1: A trigger accepted while idle with repeat field n (1 to 7) performs exactly n moves and no more. After the last write is acknowledged, done_o is high for exactly one cycle.
- R2: A trigger while idle with repeat field 0 gives an err_o pulse of one cycle in the cycle after the trigger. It makes no memory access, busy_o stays low, and done_o is not raised.
- R3: The table starts at base_addr_i + 4, after the 2-byte mode word at base_addr_i and the 2-byte count word at base_addr_i + 2. For move k (counted from 0), the source entry is read at base + 4 + 4k and the destination entry at base + 6 + 4k. Each entry is a 16-bit little-endian read (mem_wide_o = 1).
- R4: Each move issues, in this order, the source-entry fetch, the destination-entry fetch, the data read at the source and the data write at the destination. The fetches for the next move start only after the current write is acknowledged.
- R5: When wide_i is 0 at the trigger, the data read and write use mem_wide_o = 0, the moved byte sits in bits 7:0 of the write data and bits 15:8 are zero. The byte at destination + 1 is left unchanged. When wide_i is 1, a 16-bit unit is moved.
- R6: A request that has not been acknowledged stays asserted in the next cycle, with the same address, write enable and write data.
- R7: busy_o and irq_inhibit_o are high from the cycle after an accepted trigger until the final write is acknowledged. Both are low in the cycle in which done_o is high.
- R8: A trigger that arrives while busy_o is high is ignored. It causes no extra access, no restart and no second done pulse.
- R9: The base address, repeat field and unit-size select are sampled at the accepted trigger. Changes to them during a sequence have no effect on that sequence.
- R10: mem_req_o is low whenever busy_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Start request |
| base_addr_i | input | AW | Address of the channel's mode word |
| rep_i | input | RW | Number of moves per trigger (1 to 7; 0 is illegal) |
| wide_i | input | 1 | Unit size: 1 = 16-bit halfword, 0 = byte |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_wide_o | output | 1 | Access size: 1 = halfword, 0 = byte |
| mem_addr_o | output | AW | Byte address |
| mem_wdata_o | output | AW | Write data |
| mem_rdata_i | input | AW | Read data, valid together with mem_ack_i |
| mem_ack_i | input | 1 | Completes the current request in this cycle |
| busy_o | output | 1 | A sequence is in progress |
| irq_inhibit_o | output | 1 | Interrupt acceptance must be held off |
| done_o | output | 1 | One-cycle pulse after the final write |
| err_o | output | 1 | One-cycle pulse when a trigger carries repeat value 0 |

## Verification
Each fault inside the sequencer shows up at the memory port within one access.

- A table pointer that steps wrongly gives a wrong fetch address on the next table read.
- A move counter that is off by one gives an extra or a missing write before done_o.
- A latched unit size that is wrong gives a wrong access size, or a non-zero upper byte, on the very next data transfer.

A scoreboard compares every acknowledged access, in order, against the list expected from the table contents. Triggers that arrive mid-run are paired with changed inputs, so that any resampling shows up as a difference in the access stream.

// File: rtl/mxfer_pkg.sv
package mxfer_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FSRC,
    ST_FDST,
    ST_RD,
    ST_WR
  } xfer_st_e;

  localparam int unsigned DESC_OFS  = 4;  // mode word + count word
  localparam int unsigned ADDR_STEP = 2;  // one 16-bit table entry
endpackage

// File: rtl/mxfer_ctrl.sv
module mxfer_ctrl
  import mxfer_pkg::*;
#(
  parameter int unsigned RW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          trig_i,
  input  logic [RW-1:0] rep_i,
  input  logic          wide_i,
  input  logic          ack_i,
  output xfer_st_e      state_o,
  output logic          start_o,
  output logic          wide_o,
  output logic          done_o,
  output logic          err_o
);
  xfer_st_e      state_q;
  logic [RW-1:0] rep_q;
  logic [RW-1:0] idx_q;
  logic          wide_q;
  logic          last_move;

  assign start_o   = trig_i && (state_q == ST_IDLE) && (rep_i != '0);
  assign last_move = (idx_q + RW'(1)) == rep_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rep_q   <= '0;
      idx_q   <= '0;
      wide_q  <= 1'b0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (trig_i) begin
            if (rep_i == '0) begin
              err_o <= 1'b1;
            end else begin
              rep_q   <= rep_i;
              wide_q  <= wide_i;
              idx_q   <= '0;
              state_q <= ST_FSRC;
            end
          end
        end
        ST_FSRC: if (ack_i) state_q <= ST_FDST;
        ST_FDST: if (ack_i) state_q <= ST_RD;
        ST_RD:   if (ack_i) state_q <= ST_WR;
        ST_WR: begin
          if (ack_i) begin
            if (last_move) begin
              state_q <= ST_IDLE;
              done_o  <= 1'b1;
            end else begin
              idx_q   <= idx_q + RW'(1);
              state_q <= ST_FSRC;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign wide_o  = wide_q;
endmodule

// File: rtl/mxfer_dp.sv
module mxfer_dp
  import mxfer_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  xfer_st_e      state_i,
  input  logic          start_i,
  input  logic          wide_i,
  input  logic          ack_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] rdata_i,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] wdata_o
);
  localparam logic [AW-1:0] OFS  = AW'(DESC_OFS);
  localparam logic [AW-1:0] STEP = AW'(ADDR_STEP);

  logic [AW-1:0] ptr_q, src_q, dst_q, data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      data_q <= '0;
    end else begin
      if (start_i) ptr_q <= base_i + OFS;
      if (ack_i) begin
        unique case (state_i)
          ST_FSRC: begin
            src_q <= rdata_i;
            ptr_q <= ptr_q + STEP;
          end
          ST_FDST: begin
            dst_q <= rdata_i;
            ptr_q <= ptr_q + STEP;
          end
          ST_RD: data_q <= wide_i ? rdata_i : {{(AW-8){1'b0}}, rdata_i[7:0]};
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (state_i)
      ST_FSRC, ST_FDST: addr_o = ptr_q;
      ST_RD:            addr_o = src_q;
      ST_WR:            addr_o = dst_q;
      default:          addr_o = '0;
    endcase
  end

  assign wdata_o = data_q;
endmodule

// File: rtl/mxfer_seq.sv
module mxfer_seq
  import mxfer_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned RW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          trig_i,
  input  logic [AW-1:0] base_addr_i,
  input  logic [RW-1:0] rep_i,
  input  logic          wide_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic          mem_wide_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [AW-1:0] mem_wdata_o,
  input  logic [AW-1:0] mem_rdata_i,
  input  logic          mem_ack_i,
  output logic          busy_o,
  output logic          irq_inhibit_o,
  output logic          done_o,
  output logic          err_o
);
  xfer_st_e state;
  logic     start, wide_q, ack;

  assign ack = mem_ack_i && mem_req_o;

  mxfer_ctrl #(.RW(RW)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trig_i  (trig_i),
    .rep_i   (rep_i),
    .wide_i  (wide_i),
    .ack_i   (ack),
    .state_o (state),
    .start_o (start),
    .wide_o  (wide_q),
    .done_o  (done_o),
    .err_o   (err_o)
  );

  mxfer_dp #(.AW(AW)) u_dp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_i (state),
    .start_i (start),
    .wide_i  (wide_q),
    .ack_i   (ack),
    .base_i  (base_addr_i),
    .rdata_i (mem_rdata_i),
    .addr_o  (mem_addr_o),
    .wdata_o (mem_wdata_o)
  );

  assign mem_req_o     = state != ST_IDLE;
  assign mem_we_o      = state == ST_WR;
  assign mem_wide_o    = (state == ST_FSRC || state == ST_FDST) ? 1'b1 : wide_q;
  assign busy_o        = state != ST_IDLE;
  assign irq_inhibit_o = state != ST_IDLE;
endmodule

// File: rtl/mxfer_chk.sv
module mxfer_chk #(
  parameter int unsigned AW = 16,
  parameter int unsigned RW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          trig_i,
  input logic [RW-1:0] rep_i,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [AW-1:0] mem_wdata_o,
  input logic          mem_ack_i,
  input logic          busy_o,
  input logic          irq_inhibit_o,
  input logic          done_o,
  input logic          err_o
);
  logic [RW-1:0] rep_cap;
  logic [RW:0]   wr_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rep_cap <= '0;
      wr_cnt  <= '0;
    end else if (trig_i && !busy_o && rep_i != '0) begin
      rep_cap <= rep_i;
      wr_cnt  <= '0;
    end else if (mem_req_o && mem_we_o && mem_ack_i) begin
      wr_cnt <= wr_cnt + 1'b1;
    end
  end

  // R10
  idle_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);
  // R6
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)
      && $stable(mem_we_o) && $stable(mem_wdata_o));
  // R1
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R1
  move_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> wr_cnt == {1'b0, rep_cap});
  // R7
  inhibit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> irq_inhibit_o);
  // R7
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !irq_inhibit_o);
  // R2
  err_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o && !done_o);
endmodule

bind mxfer_seq mxfer_chk #(.AW(AW), .RW(RW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .trig_i        (trig_i),
  .rep_i         (rep_i),
  .mem_req_o     (mem_req_o),
  .mem_we_o      (mem_we_o),
  .mem_addr_o    (mem_addr_o),
  .mem_wdata_o   (mem_wdata_o),
  .mem_ack_i     (mem_ack_i),
  .busy_o        (busy_o),
  .irq_inhibit_o (irq_inhibit_o),
  .done_o        (done_o),
  .err_o         (err_o)
);

// File: tb/sim_mxfer_seq.sv
module sim_mxfer_seq;
  localparam int AW = 16;
  localparam int RW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          trig = 1'b0;
  logic [AW-1:0] base = '0;
  logic [RW-1:0] rep = '0;
  logic          wide = 1'b0;
  logic          req, we, mwide, busy, inh, done, err;
  logic [AW-1:0] addr, wdata;
  logic [AW-1:0] rdata = '0;
  logic          ack = 1'b0;

  always #5 clk = ~clk;

  mxfer_seq #(.AW(AW), .RW(RW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .base_addr_i(base),
    .rep_i(rep), .wide_i(wide), .mem_req_o(req), .mem_we_o(we),
    .mem_wide_o(mwide), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .mem_rdata_i(rdata), .mem_ack_i(ack), .busy_o(busy),
    .irq_inhibit_o(inh), .done_o(done), .err_o(err)
  );

  typedef struct packed {
    logic        we;
    logic        wide;
    logic [15:0] addr;
    logic [15:0] wdata;
    logic [3:0]  rq;
  } exp_t;

  exp_t       q[$];
  logic [7:0] mem[0:511];
  int         checks = 0;
  int         fails  = 0;
  int         stall  = 0;
  int         sc     = 0;
  int         cyc    = 0;
  int         done_cnt = 0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // memory model + scoreboard monitor
  always @(negedge clk) begin
    if (done) done_cnt++;
    ack = 1'b0;
    if (req) begin
      if (sc == 0) begin
        exp_t e;
        ack = 1'b1;
        sc  = stall;
        if (q.size() == 0) begin
          chk(1'b0, "R8 unexpected access", {15'd0, we, addr}, 32'hffff);
        end else begin
          e = q.pop_front();
          chk(we == e.we && mwide == e.wide && addr == e.addr,
              $sformatf("R%0d access", e.rq),
              {14'd0, we, mwide, addr}, {14'd0, e.we, e.wide, e.addr});
          if (e.we)
            chk(wdata == e.wdata, $sformatf("R%0d wdata", e.rq),
                {16'd0, wdata}, {16'd0, e.wdata});
        end
        if (we) begin
          mem[addr[8:0]] = wdata[7:0];
          if (mwide) mem[addr[8:0] + 9'd1] = wdata[15:8];
        end else begin
          rdata = mwide ? {mem[addr[8:0] + 9'd1], mem[addr[8:0]]}
                        : {8'hA5, mem[addr[8:0]]};
        end
      end else begin
        sc--;
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic run_seq(input logic [15:0] b, input int n, input bit w,
                         input logic [15:0] doff, input int st, input bit intrude);
    logic [15:0] s, d;
    logic [7:0]  keep[7];
    int          d0;
    stall = st;
    sc    = st;
    for (int k = 0; k < n; k++) begin
      s = 16'h0100 + doff + 16'(3 * k);
      d = 16'h0180 + doff + 16'(3 * k);
      mem[b + 4 + 4 * k]     = s[7:0];
      mem[b + 5 + 4 * k]     = s[15:8];
      mem[b + 6 + 4 * k]     = d[7:0];
      mem[b + 7 + 4 * k]     = d[15:8];
      keep[k] = mem[d[8:0] + 9'd1];
      // R3 table fetches, R4 order
      q.push_back('{1'b0, 1'b1, b + 16'(4 + 4 * k), 16'h0, 4'd3});
      q.push_back('{1'b0, 1'b1, b + 16'(6 + 4 * k), 16'h0, 4'd3});
      q.push_back('{1'b0, w, s, 16'h0, 4'd4});
      q.push_back('{1'b1, w, d,
                    w ? {mem[s[8:0] + 9'd1], mem[s[8:0]]} : {8'h00, mem[s[8:0]]},
                    w ? 4'd1 : 4'd5});
    end
    d0 = done_cnt;
    @(negedge clk);
    base = b; rep = RW'(n); wide = w; trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    // R7 busy and inhibit raised after accepted trigger
    chk(busy && inh, "R7 busy after trigger", {30'd0, busy, inh}, 32'h3);
    if (intrude) begin
      repeat (3) @(negedge clk);
      // R8 R9: retrigger with different settings mid-run
      base = 16'h0000; rep = 3'd5; wide = ~w; trig = 1'b1;
      @(negedge clk);
      trig = 1'b0; rep = 3'd0;
    end
    while (!done) @(negedge clk);
    // R7 low in done cycle, R1 all moves done
    chk(!busy && !inh, "R7 idle in done cycle", {30'd0, busy, inh}, 32'h0);
    chk(q.size() == 0, "R1 all moves done", q.size(), 0);
    @(negedge clk);
    chk(!done, "R1 done one cycle", {31'd0, done}, 0);
    repeat (8) @(negedge clk);
    chk(done_cnt - d0 == 1 && !busy, "R8 single run", done_cnt - d0, 1);
    if (!w)
      for (int k = 0; k < n; k++) begin
        d = 16'h0180 + doff + 16'(3 * k);
        // R5 byte beside destination untouched
        chk(mem[d[8:0] + 9'd1] == keep[k], "R5 neighbour byte",
            {24'd0, mem[d[8:0] + 9'd1]}, {24'd0, keep[k]});
      end
  endtask

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 8'(i * 7 + 3);
    #1;
    // R10 reset state
    chk(!req && !busy && !done && !err && !inh, "R10 reset outputs",
        {27'd0, req, busy, done, err, inh}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    run_seq(16'h0000, 3, 1'b1, 16'h0000, 0, 1'b0);
    run_seq(16'h0040, 7, 1'b0, 16'h0020, 2, 1'b0);
    run_seq(16'h0080, 1, 1'b1, 16'h0040, 1, 1'b0);
    run_seq(16'h00C0, 2, 1'b1, 16'h0060, 1, 1'b1);
    run_seq(16'h00E0, 4, 1'b0, 16'h0010, 0, 1'b1);
    // R2 repeat value zero
    @(negedge clk);
    base = 16'h0000; rep = 3'd0; trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    chk(err && !busy && !done, "R2 error pulse", {29'd0, err, busy, done}, 32'h4);
    @(negedge clk);
    chk(!err, "R2 error one cycle", {31'd0, err}, 0);
    repeat (6) @(negedge clk);
    chk(!busy && !done, "R2 no run", {30'd0, busy, done}, 0);
    finish_run();
  end
endmodule